// File: doc/BRIEF.md
# DMA Channel Flag Command Registers

This block keeps three flag vectors for up to 64 DMA channels: a START flag that asks for channel service, a DONE flag that marks a finished transfer, and an interrupt-request flag. Software does not write bitmaps to change START and DONE. It writes one command byte that names a single channel by number, or all channels at once. One byte sets START and another byte clears DONE. The transfer engine drives per-channel pulses that clear START, set DONE and raise interrupt requests. Software reads the interrupt-request flags as two 32-bit words and clears them by writing ones.

The bus is a simple register port. Every request completes in the cycle it is presented, and the read data is combinational from the current flags. A parameter selects a reduced 32-channel build. In that build the upper interrupt word answers with a bus error, and command numbers that fall above the implemented channels are dropped.

Top module: `dma_flag_regs`

## Requirements
- R1: After reset, every START, DONE and interrupt-request flag is 0.
- R2: A write to byte address 0x1E (word 0x1C, byte lane 2, wdata[23:16]) whose bit 6 is 0 sets the START flag of the channel numbered by bits 5:0. Only that flag changes. Bit 7 of the byte is ignored.
- R3: A write to byte address 0x1F (word 0x1C, byte lane 3, wdata[31:24]) whose bit 6 is 0 clears the DONE flag of the channel numbered by bits 5:0. Bit 7 is ignored.
- R4: A command byte with bit 6 set (value 64 to 127) applies its action to every implemented channel.
- R5: A read of the command word 0x1C returns 0.
- R6: An engine start-clear pulse clears that channel's START flag in the next cycle, and an engine done-set pulse sets that channel's DONE flag. When a set and a clear hit the same flag in the same cycle, the flag ends up set.
- R7: An engine interrupt pulse sets that channel's interrupt flag. A read of word 0x28 returns channels 31 to 0 (bit n = channel n). A read of word 0x24 returns channels 63 to 32 (bit n = channel 32+n).
- R8: A write to 0x28 or 0x24 clears each interrupt flag whose data bit is 1 in an enabled byte lane. Bits written as 0 keep their value. An engine interrupt pulse in the same cycle wins.
- R9: With NUM_CH = 32, any access to word 0x24 raises bus_err and changes nothing. Command values 32 to 63 change no flag, all-channel commands touch only channels 0 to 31, and flags 63 to 32 stay 0.
- R10: bus_ready equals bus_valid in every cycle. Reads of unmapped or non-word-aligned addresses return 0 with bus_err low.
- R11: A command byte acts only when its byte lane enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (0 when not a read) |
| bus_ready | output | 1 | Request completes this cycle |
| bus_err | output | 1 | Access error |
| eng_start_clr | input | 64 | Engine pulses that clear START |
| eng_done_set | input | 64 | Engine pulses that set DONE |
| eng_irq_set | input | 64 | Engine pulses that raise interrupt flags |
| start_flags | output | 64 | Current START flags |
| done_flags | output | 64 | Current DONE flags |
| irq_flags | output | 64 | Current interrupt-request flags |

## Verification
The bench builds two copies of the block side by side, one with NUM_CH = 64 and one with NUM_CH = 32, and drives both with the same stimulus. Every command byte and every upper-word access is therefore checked in both builds at once. This exposes the reduced build's error response, its dropped channel numbers and its narrowed all-channel commands, alongside the full build that accepts the same writes.

// File: rtl/dma_flag_pkg.sv
package dma_flag_pkg;
  localparam int MAX_CH = 64;
  typedef logic [MAX_CH-1:0] ch_vec_t;
  typedef logic [6:0]        cmd_t;

  localparam logic [7:0] OFF_CMD    = 8'h1C;  // lane 2: set START, lane 3: clear DONE
  localparam logic [7:0] OFF_IRQ_HI = 8'h24;
  localparam logic [7:0] OFF_IRQ_LO = 8'h28;

  // Channels that exist in a build with n channels.
  function automatic ch_vec_t impl_mask(int n);
    ch_vec_t m;
    for (int i = 0; i < MAX_CH; i++) m[i] = (i < n);
    return m;
  endfunction

  // Channels that one command value acts on.
  function automatic ch_vec_t cmd_to_mask(cmd_t v, int n);
    ch_vec_t m;
    m = '0;
    if (v[6]) m = impl_mask(n);
    else if (int'(v[5:0]) < n) m[v[5:0]] = 1'b1;
    return m;
  endfunction

  // Expands byte lane enables to a 32-bit bit mask.
  function automatic logic [31:0] lane_mask(logic [3:0] be);
    logic [31:0] m;
    for (int l = 0; l < 4; l++) m[l*8 +: 8] = {8{be[l]}};
    return m;
  endfunction
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_flag_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic    fire,
  input  cmd_t    cmd,
  output ch_vec_t mask
);
  assign mask = fire ? cmd_to_mask(cmd, NUM_CH) : '0;
endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank
  import dma_flag_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  ch_vec_t set_vec,
  input  ch_vec_t clr_vec,
  output ch_vec_t q
);
  localparam ch_vec_t IMPL = impl_mask(NUM_CH);

  ch_vec_t set_eff;
  ch_vec_t clr_only;
  ch_vec_t touched;
  assign set_eff  = set_vec & IMPL;
  assign clr_only = clr_vec & ~set_vec & IMPL;
  assign touched  = set_vec | clr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= IMPL & ((q & ~clr_vec) | set_vec);
  end

  // R6 / R8: a set always lands, even against a clear
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_eff != '0) |=> ((q & $past(set_eff)) == $past(set_eff)));

  // R8: a clear without a competing set empties the flag
  assert_clear_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_only != '0) |=> ((q & $past(clr_only)) == '0));

  // R2: untouched flags keep their value
  assert_untouched_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(q)) & ~$past(touched)) == '0));

  // R9: flags above the build's channel count never rise
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~IMPL) == '0);
endmodule

// File: rtl/dma_bus_port.sv
module dma_bus_port
  import dma_flag_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [7:0]  bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  input  ch_vec_t     irq_q,
  output logic [31:0] bus_rdata,
  output logic        bus_ready,
  output logic        bus_err,
  output logic        start_fire,
  output cmd_t        start_cmd,
  output logic        done_fire,
  output cmd_t        done_cmd,
  output ch_vec_t     irq_clr
);
  localparam bit HAS_HI = (NUM_CH > 32);

  logic hit_cmd, hit_hi, hit_lo, wr_ok, rd_req;
  assign hit_cmd = (bus_addr == OFF_CMD);
  assign hit_hi  = (bus_addr == OFF_IRQ_HI);
  assign hit_lo  = (bus_addr == OFF_IRQ_LO);

  assign bus_ready = bus_valid;
  assign bus_err   = bus_valid && hit_hi && !HAS_HI;
  assign wr_ok     = bus_valid && bus_write && !bus_err;
  assign rd_req    = bus_valid && !bus_write;

  assign start_fire = wr_ok && hit_cmd && bus_be[2];
  assign start_cmd  = bus_wdata[22:16];
  assign done_fire  = wr_ok && hit_cmd && bus_be[3];
  assign done_cmd   = bus_wdata[30:24];

  // One write-one-to-clear half per interrupt word
  for (genvar h = 0; h < 2; h++) begin : g_irq_half
    logic hit_h;
    assign hit_h = (h == 0) ? hit_lo : hit_hi;
    if (h == 0 || HAS_HI) begin : g_live
      assign irq_clr[h*32 +: 32] = (wr_ok && hit_h) ? (bus_wdata & lane_mask(bus_be)) : '0;
    end else begin : g_absent
      assign irq_clr[h*32 +: 32] = '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_req) begin
      if (hit_lo)                bus_rdata = irq_q[31:0];
      else if (hit_hi && HAS_HI) bus_rdata = irq_q[63:32];
    end
  end
endmodule

// File: rtl/dma_flag_regs.sv
module dma_flag_regs
  import dma_flag_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [7:0]  bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ready,
  output logic        bus_err,
  input  logic [63:0] eng_start_clr,
  input  logic [63:0] eng_done_set,
  input  logic [63:0] eng_irq_set,
  output logic [63:0] start_flags,
  output logic [63:0] done_flags,
  output logic [63:0] irq_flags
);
  localparam ch_vec_t IMPL = impl_mask(NUM_CH);

  logic    start_fire, done_fire;
  cmd_t    start_cmd, done_cmd;
  ch_vec_t start_mask, done_mask, irq_clr;

  dma_bus_port #(.NUM_CH(NUM_CH)) u_port (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .irq_q(irq_flags),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
    .start_fire(start_fire), .start_cmd(start_cmd),
    .done_fire(done_fire), .done_cmd(done_cmd), .irq_clr(irq_clr)
  );

  dma_cmd_decode #(.NUM_CH(NUM_CH)) u_dec_start (
    .fire(start_fire), .cmd(start_cmd), .mask(start_mask));
  dma_cmd_decode #(.NUM_CH(NUM_CH)) u_dec_done (
    .fire(done_fire), .cmd(done_cmd), .mask(done_mask));

  dma_flag_bank #(.NUM_CH(NUM_CH)) u_start (
    .clk(clk), .rst_n(rst_n), .set_vec(start_mask), .clr_vec(eng_start_clr), .q(start_flags));
  dma_flag_bank #(.NUM_CH(NUM_CH)) u_done (
    .clk(clk), .rst_n(rst_n), .set_vec(eng_done_set), .clr_vec(done_mask), .q(done_flags));
  dma_flag_bank #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(eng_irq_set), .clr_vec(irq_clr), .q(irq_flags));

  // R2: a single-channel command touches at most one channel
  assert_single_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_fire && !start_cmd[6]) |-> $onehot0(start_mask));

  // R4: an all-channel set leaves every implemented START flag high
  assert_all_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_fire && start_cmd[6]) |=> (start_flags == IMPL));

  // R5: the command word reads back as zero
  assert_cmd_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == OFF_CMD) |-> (bus_rdata == '0));

  // R9: errors only come from the reduced build, only on a request
  assert_err_reduced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_valid && NUM_CH <= 32));
endmodule

// File: tb/test_dma_flag_regs.sv
`timescale 1ns/1ps
module test_dma_flag_regs;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, bus_valid, bus_write;
  logic [7:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [63:0] eng_start_clr, eng_done_set, eng_irq_set;

  logic [31:0] rd_o  [0:1];
  logic        rdy_o [0:1];
  logic        err_o [0:1];
  logic [63:0] st_o  [0:1];
  logic [63:0] dn_o  [0:1];
  logic [63:0] iq_o  [0:1];

  logic [63:0] m_st [0:1];
  logic [63:0] m_dn [0:1];
  logic [63:0] m_iq [0:1];

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  dma_flag_regs #(.NUM_CH(64)) i_dma_flag_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(rd_o[0]), .bus_ready(rdy_o[0]), .bus_err(err_o[0]),
    .eng_start_clr(eng_start_clr), .eng_done_set(eng_done_set), .eng_irq_set(eng_irq_set),
    .start_flags(st_o[0]), .done_flags(dn_o[0]), .irq_flags(iq_o[0]));

  dma_flag_regs #(.NUM_CH(32)) i_dma_flag_regs_n32 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(rd_o[1]), .bus_ready(rdy_o[1]), .bus_err(err_o[1]),
    .eng_start_clr(eng_start_clr), .eng_done_set(eng_done_set), .eng_irq_set(eng_irq_set),
    .start_flags(st_o[1]), .done_flags(dn_o[1]), .irq_flags(iq_o[1]));

  function automatic int nch(int b);
    return (b == 0) ? 64 : 32;
  endfunction

  function automatic bit cmd_hits(logic [6:0] v, int ch, int n);
    if (ch >= n) return 0;
    if (v >= 7'd64) return 1;
    return (int'(v) == ch);
  endfunction

  function automatic logic exp_err(int b);
    return bus_valid && (bus_addr == 8'h24) && (nch(b) == 32);
  endfunction

  function automatic logic [31:0] exp_rdata(int b);
    if (!bus_valid || bus_write) return 32'h0;
    if (bus_addr == 8'h28) return m_iq[b][31:0];
    if (bus_addr == 8'h24 && nch(b) == 64) return m_iq[b][63:32];
    return 32'h0;
  endfunction

  task automatic check(string tag, string what, int b, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s build%0d: actual %h expected %h", tag, what, nch(b), act, exp);
    end
  endtask

  task automatic model_step(int b);
    int  n;
    bit  wr, ss, dc, ic;
    n  = nch(b);
    wr = bus_valid && bus_write && !exp_err(b);
    for (int ch = 0; ch < 64; ch++) begin
      ss = wr && bus_addr == 8'h1C && bus_be[2] && cmd_hits(bus_wdata[22:16], ch, n);
      dc = wr && bus_addr == 8'h1C && bus_be[3] && cmd_hits(bus_wdata[30:24], ch, n);
      if (ch < 32) ic = wr && bus_addr == 8'h28 && bus_be[ch/8] && bus_wdata[ch];
      else         ic = wr && bus_addr == 8'h24 && bus_be[(ch-32)/8] && bus_wdata[ch-32];
      if (ch >= n) begin
        m_st[b][ch] = 1'b0; m_dn[b][ch] = 1'b0; m_iq[b][ch] = 1'b0;
      end else begin
        m_st[b][ch] = ss | (m_st[b][ch] & !eng_start_clr[ch]);
        m_dn[b][ch] = eng_done_set[ch] | (m_dn[b][ch] & !dc);
        m_iq[b][ch] = eng_irq_set[ch] | (m_iq[b][ch] & !ic);
      end
    end
  endtask

  task automatic idle();
    bus_valid = 0; bus_write = 0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    eng_start_clr = '0; eng_done_set = '0; eng_irq_set = '0;
  endtask

  task automatic cycle(string tag);
    #1;
    for (int b = 0; b < 2; b++) begin
      check(tag, "ready", b, 64'(rdy_o[b]), 64'(bus_valid));
      check(tag, "err", b, 64'(err_o[b]), 64'(exp_err(b)));
      check(tag, "rdata", b, 64'(rd_o[b]), 64'(exp_rdata(b)));
    end
    @(posedge clk);
    for (int b = 0; b < 2; b++) model_step(b);
    @(negedge clk);
    for (int b = 0; b < 2; b++) begin
      check(tag, "start", b, st_o[b], m_st[b]);
      check(tag, "done", b, dn_o[b], m_dn[b]);
      check(tag, "irq", b, iq_o[b], m_iq[b]);
    end
    idle();
  endtask

  task automatic bus_wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_be = be; bus_wdata = d;
  endtask

  task automatic bus_rd(logic [7:0] a);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_be = 4'hF;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0;
    idle();
    for (int b = 0; b < 2; b++) begin m_st[b] = '0; m_dn[b] = '0; m_iq[b] = '0; end
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int b = 0; b < 2; b++) begin
      check("R1", "start", b, st_o[b], 64'h0);
      check("R1", "done", b, dn_o[b], 64'h0);
      check("R1", "irq", b, iq_o[b], 64'h0);
    end
    rst_n = 1;

    bus_wr(8'h1C, 4'b0100, 32'h0005_0000); cycle("R2");
    bus_wr(8'h1C, 4'b0100, 32'h00BF_0000); cycle("R2/R9");
    eng_start_clr = 64'h20;                cycle("R6");
    eng_done_set = '1;                     cycle("R6/R9");
    bus_wr(8'h1C, 4'b1000, 32'h0300_0000); cycle("R3");
    bus_wr(8'h1C, 4'b0000, 32'hC0C0_0000); cycle("R11");
    bus_wr(8'h1C, 4'b0100, 32'hC000_0000); cycle("R11");
    bus_wr(8'h1C, 4'b1000, 32'hC000_0000);
    eng_done_set = 64'h80;                 cycle("R4/R6");
    bus_wr(8'h1C, 4'b0100, 32'h007F_0000); cycle("R4");
    bus_wr(8'h1C, 4'b0100, 32'h0041_0000);
    eng_start_clr = '1;                    cycle("R6");
    eng_start_clr = '1;                    cycle("R6");
    bus_wr(8'h1C, 4'b0100, 32'h0028_0000); cycle("R9");
    bus_rd(8'h1C);                         cycle("R5");
    bus_rd(8'h20);                         cycle("R10");
    bus_rd(8'h29);                         cycle("R10");
    eng_irq_set = 64'hF000_0001_8000_0003; cycle("R7");
    bus_rd(8'h28);                         cycle("R7");
    bus_rd(8'h24);                         cycle("R7/R9");
    bus_wr(8'h28, 4'b0001, 32'h0000_0001); cycle("R8");
    bus_wr(8'h28, 4'b1110, 32'hFFFF_FFFF);
    eng_irq_set = 64'h8000_0000;           cycle("R8");
    bus_wr(8'h24, 4'hF, 32'hFFFF_FFFF);    cycle("R8/R9");

    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom % 6;
      bus_valid = ($urandom % 4) != 0;
      bus_write = $urandom % 2;
      case (sel)
        0, 1: bus_addr = 8'h1C;
        2:    bus_addr = 8'h24;
        3:    bus_addr = 8'h28;
        4:    bus_addr = 8'h20;
        default: bus_addr = 8'($urandom);
      endcase
      bus_be    = 4'($urandom);
      bus_wdata = $urandom;
      eng_start_clr = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      eng_done_set  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      eng_irq_set   = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      cycle("R2/R3/R4/R6/R7/R8/R9/R10/R11");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule